// File: doc/BRIEF.md
# Snoop-Invalidated Instruction Prefetch Cache

This block is a small direct-mapped instruction cache that sits between a CPU's fetch stage and a paging MMU. The CPU asks for instruction words by virtual word address. A hit returns the word on the next cycle. A miss stalls the fetch port while the whole line is read over a pipelined memory read port, and then the requested word is returned.

While a line fill is in progress, the MMU reports the translation it used on a snoop channel. The cache keeps the physical page number from that report beside the line's tag, together with the report's cacheable flag. The prefetcher never writes to memory. When the MMU later reports a data write to a physical page, every line recorded against that page loses its valid bit. Lines are smaller than pages, so one write can drop several lines at once.

A line becomes valid only when its fill completes cleanly. The fill must have been marked cacheable, must have ended without a bus error, and must not have been hit by a conflicting write or a flush while it ran.

Top module: `snoop_prefetch_cache`

## Requirements
- R1: After reset no line is valid, and `stall`, `rsp_valid` and `mem_cyc` are low.
- R2: A request is accepted on a clock edge where `req_valid` is high and `stall` is low. If the addressed line is valid and its tag matches, `rsp_valid` is high with the word and `rsp_err` low in the cycle after acceptance, and no memory cycle starts.
- R3: On a miss, `stall` is high from the cycle after acceptance until the fill ends. The fill reads the 8 words of the line in order, at word addresses line base + 0 through line base + 7. The requested word appears with `rsp_valid` in the cycle after the last acknowledge, and `stall` falls in that same cycle.
- R4: Word address bits [2:0] select the word, bits [5:3] select the line and bits [23:6] form the tag. A fill to a line index replaces whatever that index held before.
- R5: During a fill, a snoop with `snp_stb`=1, `snp_we`=0 and `snp_vpage` equal to address bits [23:10] of the fill records the physical page and cacheable flag. The line is marked valid at completion only if the recorded cacheable flag was 1. Otherwise the word is still returned.
- R6: A snoop with `snp_stb`=1 and `snp_we`=1 clears, from the next cycle, the valid bit of every line whose recorded physical page equals `snp_ppage`. `snp_vpage` plays no part in this.
- R7: A snoop with `snp_we`=0 while no fill is running changes no line.
- R8: A write snoop to the physical page already recorded for the running fill lets the fill finish and return its word, but leaves the line invalid.
- R9: A one-cycle `flush` pulse clears every valid bit.
- R10: A bus error during a fill ends the fill. The requested fetch then gets `rsp_valid` with `rsp_err`=1, and the line stays invalid.
- R11: While `mem_stall` is high, `mem_addr` holds the pending address. Every word of the line is still stored correctly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate all lines |
| req_valid | input | 1 | Fetch request |
| req_addr | input | 24 | Virtual word address of the fetch |
| stall | output | 1 | Fetch port busy with a line fill |
| rsp_valid | output | 1 | Fetch response strobe |
| rsp_data | output | 32 | Fetched instruction word |
| rsp_err | output | 1 | Fetch ended in a bus error |
| mem_cyc | output | 1 | Memory cycle active during a fill |
| mem_stb | output | 1 | Memory read request strobe |
| mem_addr | output | 24 | Memory word address |
| mem_stall | input | 1 | Memory cannot take the request |
| mem_ack | input | 1 | Read data valid |
| mem_err | input | 1 | Bus error |
| mem_data | input | 32 | Read data |
| snp_stb | input | 1 | Snoop report valid |
| snp_we | input | 1 | Snoop report is a data write |
| snp_ppage | input | 14 | Physical page number |
| snp_vpage | input | 14 | Virtual page number |
| snp_cacheable | input | 1 | Page may be cached |

## Verification
A hit response is due exactly one edge after the accepting edge. A miss or error response is due one edge after the final acknowledge, or after the error, so it always comes later than a hit. The driver stamps each request with a free-running cycle count taken just before the accepting edge. The monitor samples on falling edges and requires a hit to arrive at stamp + 1 and a miss strictly later. Because of this, a refetch after a snoop, flush or error shows whether the line survived through the response time alone. Snoop effects take hold one edge after the snoop, so each snoop is followed by at least one idle cycle before the next probing fetch.

// File: rtl/pfc_pkg.sv
`timescale 1ns/1ps
package pfc_pkg;
    localparam int AW    = 24;   // word address width
    localparam int DW    = 32;   // instruction word width
    localparam int LINES = 8;    // direct-mapped lines
    localparam int WORDS = 8;    // words per line
    localparam int PGW   = 10;   // word offset bits inside a page
    localparam int PPW   = 14;   // physical page number width

    localparam int OFFW  = $clog2(WORDS);
    localparam int IDXW  = $clog2(LINES);
    localparam int TAGW  = AW - OFFW - IDXW;
    localparam int LW    = AW - OFFW;     // line address width
    localparam int VPW   = AW - PGW;      // virtual page number width

    typedef struct packed {
        logic [TAGW-1:0] tag;
        logic [IDXW-1:0] idx;
        logic [OFFW-1:0] off;
    } fetch_addr_t;

    typedef struct packed {
        logic           stb;
        logic           we;
        logic [PPW-1:0] ppage;
        logic [VPW-1:0] vpage;
        logic           cacheable;
    } snoop_t;

    function automatic logic [VPW-1:0] line_vpage(input logic [LW-1:0] line);
        return line[LW-1 -: VPW];
    endfunction
endpackage

// File: rtl/pfc_lines.sv
`timescale 1ns/1ps
module pfc_lines
    import pfc_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 flush,
    input  logic [IDXW-1:0]      rd_idx,
    input  logic [OFFW-1:0]      rd_off,
    output logic                 rd_valid,
    output logic [TAGW-1:0]      rd_tag,
    output logic [DW-1:0]        rd_data,
    input  logic                 clr_en,
    input  logic [IDXW-1:0]      fill_idx,
    input  logic                 wr_en,
    input  logic [OFFW-1:0]      wr_off,
    input  logic [DW-1:0]        wr_data,
    input  logic                 set_en,
    input  logic [TAGW-1:0]      set_tag,
    input  logic [PPW-1:0]       set_ppage,
    input  logic                 inv_en,
    input  logic [PPW-1:0]       inv_ppage
);
    logic [LINES-1:0] valid_q;
    logic [TAGW-1:0]  tag_q  [LINES];
    logic [PPW-1:0]   page_q [LINES];
    logic [DW-1:0]    data_q [LINES][WORDS];

    assign rd_valid = valid_q[rd_idx];
    assign rd_tag   = tag_q[rd_idx];
    assign rd_data  = data_q[rd_idx][rd_off];

    always_ff @(posedge clk) begin
        if (wr_en)
            data_q[fill_idx][wr_off] <= wr_data;
        if (set_en) begin
            tag_q[fill_idx]  <= set_tag;
            page_q[fill_idx] <= set_ppage;
        end
    end

    for (genvar i = 0; i < LINES; i++) begin : g_line
        logic page_hit;
        assign page_hit = inv_en && (page_q[i] == inv_ppage);

        always_ff @(posedge clk) begin
            if (rst || flush)
                valid_q[i] <= 1'b0;
            else if (page_hit || (clr_en && fill_idx == IDXW'(i)))
                valid_q[i] <= 1'b0;
            else if (set_en && fill_idx == IDXW'(i))
                valid_q[i] <= 1'b1;
        end

        // R6
        inv_clear_chk: assert property (@(posedge clk) disable iff (rst)
            (inv_en && valid_q[i] && page_q[i] == inv_ppage) |=> !valid_q[i]);
    end

    // R9
    flush_all_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> ($countones(valid_q) == 0));
endmodule

// File: rtl/pfc_fill.sv
`timescale 1ns/1ps
module pfc_fill
    import pfc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic [LW-1:0]   start_line,
    input  logic [OFFW-1:0] start_off,
    input  logic            flush,
    input  snoop_t          snp,
    output logic            busy,
    output logic [LW-1:0]   line,
    output logic            mem_cyc,
    output logic            mem_stb,
    output logic [AW-1:0]   mem_addr,
    input  logic            mem_stall,
    input  logic            mem_ack,
    input  logic            mem_err,
    input  logic [DW-1:0]   mem_data,
    output logic            wr_en,
    output logic [OFFW-1:0] wr_off,
    output logic            done,
    output logic            done_err,
    output logic            done_keep,
    output logic [PPW-1:0]  cap_ppage,
    output logic [DW-1:0]   rsp_word
);
    logic            busy_q, got_q, cach_q, poison_q;
    logic [LW-1:0]   line_q;
    logic [OFFW-1:0] off_q, ack_q;
    logic [OFFW:0]   iss_q;
    logic [PPW-1:0]  pp_q;
    logic [DW-1:0]   hold_q;
    logic            ack_ok, last, err_now, xlat, poison_now, want_word;

    assign busy     = busy_q;
    assign line     = line_q;
    assign mem_cyc  = busy_q;
    assign mem_stb  = busy_q && !iss_q[OFFW];
    assign mem_addr = {line_q, iss_q[OFFW-1:0]};

    assign ack_ok    = busy_q && mem_ack && !mem_err;
    assign err_now   = busy_q && mem_err;
    assign last      = ack_ok && (ack_q == OFFW'(WORDS-1));
    assign want_word = ack_ok && (ack_q == off_q);

    assign xlat       = busy_q && snp.stb && !snp.we && (snp.vpage == line_vpage(line_q));
    assign poison_now = flush || (snp.stb && snp.we && got_q && snp.ppage == pp_q);

    assign wr_en     = ack_ok;
    assign wr_off    = ack_q;
    assign done      = last || err_now;
    assign done_err  = err_now;
    assign done_keep = last && cach_q && !poison_q && !poison_now;
    assign cap_ppage = pp_q;
    assign rsp_word  = want_word ? mem_data : hold_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            got_q    <= 1'b0;
            cach_q   <= 1'b0;
            poison_q <= 1'b0;
            iss_q    <= '0;
            ack_q    <= '0;
        end else if (start) begin
            busy_q   <= 1'b1;
            line_q   <= start_line;
            off_q    <= start_off;
            iss_q    <= '0;
            ack_q    <= '0;
            got_q    <= 1'b0;
            cach_q   <= 1'b0;
            poison_q <= 1'b0;
        end else if (busy_q) begin
            if (mem_stb && !mem_stall)
                iss_q <= iss_q + (OFFW+1)'(1);
            if (ack_ok)
                ack_q <= ack_q + OFFW'(1);
            if (want_word)
                hold_q <= mem_data;
            if (xlat) begin
                got_q  <= 1'b1;
                pp_q   <= snp.ppage;
                cach_q <= snp.cacheable;
            end
            if (poison_now)
                poison_q <= 1'b1;
            if (done)
                busy_q <= 1'b0;
        end
    end

    // R11
    addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_stb && mem_stall && !mem_err) |=> (mem_stb && $stable(mem_addr)));

    // R10
    err_ends_chk: assert property (@(posedge clk) disable iff (rst)
        (busy_q && mem_err) |=> !mem_cyc);
endmodule

// File: rtl/snoop_prefetch_cache.sv
`timescale 1ns/1ps
module snoop_prefetch_cache
    import pfc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            flush,
    input  logic            req_valid,
    input  logic [AW-1:0]   req_addr,
    output logic            stall,
    output logic            rsp_valid,
    output logic [DW-1:0]   rsp_data,
    output logic            rsp_err,
    output logic            mem_cyc,
    output logic            mem_stb,
    output logic [AW-1:0]   mem_addr,
    input  logic            mem_stall,
    input  logic            mem_ack,
    input  logic            mem_err,
    input  logic [DW-1:0]   mem_data,
    input  logic            snp_stb,
    input  logic            snp_we,
    input  logic [PPW-1:0]  snp_ppage,
    input  logic [VPW-1:0]  snp_vpage,
    input  logic            snp_cacheable
);
    fetch_addr_t     fa;
    snoop_t          snp;
    logic            busy, accept, hit, start;
    logic [LW-1:0]   fill_line;
    logic            rd_valid, wr_en, done, done_err, done_keep;
    logic [TAGW-1:0] rd_tag;
    logic [DW-1:0]   rd_data, rsp_word;
    logic [OFFW-1:0] wr_off;
    logic [PPW-1:0]  cap_ppage;

    assign fa  = fetch_addr_t'(req_addr);
    assign snp = '{stb: snp_stb, we: snp_we, ppage: snp_ppage,
                   vpage: snp_vpage, cacheable: snp_cacheable};

    assign accept = req_valid && !busy;
    assign hit    = rd_valid && (rd_tag == fa.tag);
    assign start  = accept && !hit;
    assign stall  = busy;

    pfc_lines u_lines (
        .clk       (clk),
        .rst       (rst),
        .flush     (flush),
        .rd_idx    (fa.idx),
        .rd_off    (fa.off),
        .rd_valid  (rd_valid),
        .rd_tag    (rd_tag),
        .rd_data   (rd_data),
        .clr_en    (start),
        .fill_idx  (start ? fa.idx : fill_line[IDXW-1:0]),
        .wr_en     (wr_en),
        .wr_off    (wr_off),
        .wr_data   (mem_data),
        .set_en    (done_keep),
        .set_tag   (fill_line[LW-1:IDXW]),
        .set_ppage (cap_ppage),
        .inv_en    (snp_stb && snp_we),
        .inv_ppage (snp_ppage)
    );

    pfc_fill u_fill (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .start_line ({fa.tag, fa.idx}),
        .start_off  (fa.off),
        .flush      (flush),
        .snp        (snp),
        .busy       (busy),
        .line       (fill_line),
        .mem_cyc    (mem_cyc),
        .mem_stb    (mem_stb),
        .mem_addr   (mem_addr),
        .mem_stall  (mem_stall),
        .mem_ack    (mem_ack),
        .mem_err    (mem_err),
        .mem_data   (mem_data),
        .wr_en      (wr_en),
        .wr_off     (wr_off),
        .done       (done),
        .done_err   (done_err),
        .done_keep  (done_keep),
        .cap_ppage  (cap_ppage),
        .rsp_word   (rsp_word)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_data  <= '0;
        end else begin
            rsp_valid <= (accept && hit) || done;
            rsp_err   <= done_err;
            rsp_data  <= done ? rsp_word : rd_data;
        end
    end

    // R2
    hit_next_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && hit) |=> (rsp_valid && !rsp_err && !mem_cyc));

    // R3
    miss_stall_chk: assert property (@(posedge clk) disable iff (rst)
        (accept && !hit) |=> stall);

    // R10
    err_flag_chk: assert property (@(posedge clk) disable iff (rst)
        rsp_err |-> rsp_valid);
endmodule

// File: tb/snoop_prefetch_cache_tb.sv
`timescale 1ns/1ps
module snoop_prefetch_cache_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        flush = 1'b0;
    logic        req_valid = 1'b0;
    logic [23:0] req_addr = '0;
    logic        stall, rsp_valid, rsp_err, mem_cyc, mem_stb;
    logic [31:0] rsp_data, mem_data;
    logic [23:0] mem_addr;
    logic        mem_stall, mem_ack, mem_err;
    logic        snp_stb, snp_we, snp_cacheable;
    logic [13:0] snp_ppage, snp_vpage;

    always #10 clk = ~clk;

    int cnt = 0;
    int n_checks = 0;
    int n_errors = 0;

    // memory / MMU model knobs
    logic        stall_on = 1'b0, err_on = 1'b0, poison_on = 1'b0, cur_cach = 1'b1;
    logic [13:0] cur_pp = '0;
    logic [23:0] err_addr = '0;
    logic        m_xl, m_wr;
    logic [13:0] m_pp, m_vp;
    logic        m_cach;
    logic        t_stb = 1'b0, t_we = 1'b0;
    logic [13:0] t_pp = '0;
    logic [23:0] addr_log[$];

    assign mem_stall     = stall_on && cnt[0];
    assign snp_stb       = m_xl || m_wr || t_stb;
    assign snp_we        = m_wr ? 1'b1 : (m_xl ? 1'b0 : t_we);
    assign snp_ppage     = (m_xl || m_wr) ? m_pp : t_pp;
    assign snp_vpage     = (m_xl || m_wr) ? m_vp : 14'h3FFF;
    assign snp_cacheable = m_xl ? m_cach : 1'b1;

    function automatic logic [31:0] word_of(input logic [23:0] a);
        return {8'h5A, a};
    endfunction

    snoop_prefetch_cache u_dut (.*);

    always @(posedge clk) cnt <= cnt + 1;

    always @(posedge clk) begin
        if (rst) begin
            mem_ack <= 1'b0; mem_err <= 1'b0; m_xl <= 1'b0; m_wr <= 1'b0;
            mem_data <= '0; m_pp <= '0; m_vp <= '0; m_cach <= 1'b0;
        end else begin
            mem_ack <= 1'b0; mem_err <= 1'b0; m_xl <= 1'b0; m_wr <= 1'b0;
            if (mem_cyc && mem_stb && !mem_stall) begin
                addr_log.push_back(mem_addr);
                if (err_on && mem_addr == err_addr)
                    mem_err <= 1'b1;
                else begin
                    mem_ack  <= 1'b1;
                    mem_data <= word_of(mem_addr);
                end
                if (mem_addr[2:0] == 3'd0) begin
                    m_xl <= 1'b1; m_pp <= cur_pp; m_vp <= mem_addr[23:10]; m_cach <= cur_cach;
                end
                if (poison_on && mem_addr[2:0] == 3'd4) begin
                    m_wr <= 1'b1; m_pp <= cur_pp; m_vp <= mem_addr[23:10];
                end
            end
        end
    end

    typedef struct {
        logic [31:0] d;
        logic        e;
        logic        h;
        int          t;
        string       r;
    } exp_t;
    exp_t exp_q[$];

    task automatic fail_line(input string r, input string what, input longint act, input longint exp);
        n_errors++;
        $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    endtask

    // monitor
    always @(negedge clk) begin
        if (!rst && rsp_valid) begin
            if (exp_q.size() == 0) begin
                n_checks++;
                fail_line("R2", "unexpected response", 1, 0);
            end else begin
                exp_t x;
                bit bad;
                x = exp_q.pop_front();
                n_checks++;
                bad = 0;
                if (rsp_err !== x.e) begin
                    bad = 1; fail_line(x.r, "rsp_err", rsp_err, x.e);
                end
                if (!x.e && rsp_data !== x.d) begin
                    bad = 1; fail_line(x.r, "rsp_data", rsp_data, x.d);
                end
                if (x.h && cnt != x.t + 1) begin
                    bad = 1; fail_line(x.r, "hit response cycle", cnt - x.t, 1);
                end
                if (!x.h && cnt <= x.t + 1) begin
                    bad = 1; fail_line(x.r, "miss response cycle (expected > 1)", cnt - x.t, 2);
                end
                if (bad) n_errors = n_errors - 1 + 1;
            end
        end
    end

    task automatic fetch(input logic [23:0] a, input logic h, input logic e, input string r);
        exp_t x;
        @(negedge clk);
        while (stall) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = a;
        x.d = word_of(a); x.e = e; x.h = h; x.t = cnt; x.r = r;
        exp_q.push_back(x);
        @(negedge clk);
        req_valid = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    task automatic snoop(input logic we, input logic [13:0] pp);
        @(negedge clk);
        t_stb = 1'b1; t_we = we; t_pp = pp;
        @(negedge clk);
        t_stb = 1'b0; t_we = 1'b0;
    endtask

    task automatic check_fill_order(input logic [23:0] base, input string r);
        bit ok;
        ok = (addr_log.size() == 8);
        for (int i = 0; i < 8 && ok; i++)
            if (addr_log[i] !== base + 24'(i)) ok = 0;
        n_checks++;
        if (!ok)
            fail_line(r, "fill address sequence size", addr_log.size(), 8);
        addr_log.delete();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        fail_line("R1", "watchdog expired", cnt, 100000);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        n_checks++;
        if (stall !== 1'b0 || rsp_valid !== 1'b0 || mem_cyc !== 1'b0)
            fail_line("R1", "stall/rsp_valid/mem_cyc", {stall, rsp_valid, mem_cyc}, 0);

        // R1, R3, R5: first fetch misses, fills line in order
        addr_log.delete();
        cur_pp = 14'd5;
        fetch(24'h00040A, 1'b0, 1'b0, "R1");
        check_fill_order(24'h000408, "R3");
        // R2: hits on same line
        fetch(24'h00040A, 1'b1, 1'b0, "R2");
        fetch(24'h00040F, 1'b1, 1'b0, "R2");

        cur_pp = 14'd7;
        fetch(24'h000812, 1'b0, 1'b0, "R3");
        fetch(24'h000812, 1'b1, 1'b0, "R2");

        // R6: write snoop to page 5 drops line A, not B
        snoop(1'b1, 14'd5);
        fetch(24'h000812, 1'b1, 1'b0, "R6");
        cur_pp = 14'd5;
        fetch(24'h00040A, 1'b0, 1'b0, "R6");

        // R6: one write drops every line of the page
        cur_pp = 14'd9;
        fetch(24'h000C1B, 1'b0, 1'b0, "R6");
        fetch(24'h000C20, 1'b0, 1'b0, "R6");
        fetch(24'h000C1B, 1'b1, 1'b0, "R6");
        snoop(1'b1, 14'd9);
        fetch(24'h000C1B, 1'b0, 1'b0, "R6");
        fetch(24'h000C20, 1'b0, 1'b0, "R6");

        // R7: read snoop outside a fill changes nothing
        snoop(1'b0, 14'd7);
        fetch(24'h000812, 1'b1, 1'b0, "R7");

        // R5: non-cacheable fill returns word but stays invalid
        cur_pp = 14'd3; cur_cach = 1'b0;
        fetch(24'h00102A, 1'b0, 1'b0, "R5");
        fetch(24'h00102A, 1'b0, 1'b0, "R5");
        cur_cach = 1'b1;

        // R8: write to the filling page during the fill
        cur_pp = 14'd11; poison_on = 1'b1;
        fetch(24'h001431, 1'b0, 1'b0, "R8");
        poison_on = 1'b0;
        fetch(24'h001431, 1'b0, 1'b0, "R8");
        fetch(24'h001431, 1'b1, 1'b0, "R8");

        // R11: memory stalls during the fill
        cur_pp = 14'd12; stall_on = 1'b1;
        addr_log.delete();
        fetch(24'h00183C, 1'b0, 1'b0, "R11");
        check_fill_order(24'h001838, "R11");
        stall_on = 1'b0;
        for (int i = 0; i < 8; i++)
            fetch(24'h001838 + 24'(i), 1'b1, 1'b0, "R11");

        // R4: conflicting tag on the same index evicts
        cur_pp = 14'd13;
        fetch(24'h004812, 1'b0, 1'b0, "R4");
        cur_pp = 14'd7;
        fetch(24'h000812, 1'b0, 1'b0, "R4");
        fetch(24'h000812, 1'b1, 1'b0, "R4");

        // R10: bus error during a fill
        cur_pp = 14'd13; err_on = 1'b1; err_addr = 24'h004813;
        fetch(24'h004815, 1'b0, 1'b1, "R10");
        err_on = 1'b0;
        fetch(24'h004815, 1'b0, 1'b0, "R10");
        fetch(24'h004815, 1'b1, 1'b0, "R10");

        // R9: flush drops everything
        fetch(24'h00183C, 1'b1, 1'b0, "R9");
        @(negedge clk);
        flush = 1'b1;
        @(negedge clk);
        flush = 1'b0;
        fetch(24'h00183C, 1'b0, 1'b0, "R9");
        fetch(24'h004815, 1'b0, 1'b0, "R9");

        repeat (3) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end
endmodule